// File: doc/BRIEF.md
# Skewed Four-Bank Vector Scratchpad

This block is a small on-chip scratchpad that serves four-element vectors of 16-bit fixed-point values to a datapath. Storage is split into four single-port banks. The address space is a set of 4x4 tiles. A request names a tile, a base position inside the tile and a stride. The stride is either a row, meaning four consecutive positions, or a column, meaning four positions spaced by four. A mode input selects how tile positions are placed in the banks, so the same traffic can be compared across placements. The modes are a single wide bank, plain low-order interleaving, and a skewed placement that rotates each row by its row number.

When two elements of one request need the same bank at different lines, the request is served over several beats. The requester sees `req_ready` held low for exactly as many cycles as the request needs. Read results return in logical element order, one cycle after the last beat. A stall counter accumulates every beat beyond the first.

Top module: `pmbv_mem`

## Requirements
- R1: A synchronous reset brings the block to idle: `req_ready` high, `rsp_valid` low and `stall_count` zero.
- R2: Element i (i = 0..3) of a request has tile position p = (base + i) mod 16 for row stride (`req_stride`=0) and p = (base + 4i) mod 16 for column stride (`req_stride`=1). Here r = p[3:2] and c = p[1:0]. The element is stored at line tile*4 + r of physical bank c in modes 0 and 1, and of physical bank (r + c) mod 4 in modes 2 and 3.
- R3: In mode 0 (single wide bank), the beat count of a request equals the number of distinct rows r it touches. An aligned row takes 1 beat, a row crossing a row boundary takes 2, and a column takes 4.
- R4: In mode 1 (interleaved), every row-stride request takes 1 beat and every column-stride request takes 4 beats.
- R5: In modes 2 and 3 (skewed), every column-stride request and every aligned row takes 1 beat. A row-stride request with base mod 4 not equal to 0 takes 2 beats.
- R6: A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` is then low for exactly the request's beat count of cycles, and high again in the following cycle.
- R7: For a read (`req_write`=0), `rsp_valid` is high for exactly one cycle: the cycle right after the last beat. `rsp_rdata` holds element i in bits [16i+15:16i]. A write raises no `rsp_valid`.
- R8: A write stores element i of `req_wdata` (same bit layout) at the place given by R2. A later read returns the last value written to each place, and places in other tiles are unchanged.
- R9: `stall_count` grows by the beat count minus one for every request, is unchanged while idle, and is cleared by the synchronous reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write vector, 0 = read vector |
| req_mode | input | 2 | 0 single bank, 1 interleaved, 2/3 skewed |
| req_stride | input | 1 | 0 row, 1 column |
| req_tile | input | TILE_W (2) | Tile number |
| req_base | input | 4 | Base position inside the tile |
| req_wdata | input | 4*ELEM_W (64) | Write vector, element i in lane i |
| rsp_valid | output | 1 | Read vector valid |
| rsp_rdata | output | 4*ELEM_W (64) | Read vector in logical order |
| stall_count | output | CNT_W (16) | Accumulated conflict stall cycles |

## Verification
The read response and the acceptance of the next request share one cycle. In that cycle `rsp_valid` is high and `req_ready` has just returned high. The bench keeps `req_valid` asserted with the next request while the previous response is still on the port. It then checks that the response data match the reference memory and that the new request's stall window starts on the very next edge. Sequences with idle gaps between requests are also run, so both the overlapped and the isolated cases are judged against the same behavioural model.

// File: rtl/pmbv_pkg.sv
package pmbv_pkg;
    localparam int LANES    = 4;   // elements per vector, also tile side
    localparam int IDX_W    = 2;   // index width for a lane, row or bank
    localparam int POS_W    = 4;   // position inside a 4x4 tile

    localparam logic [1:0] MODE_SINGLE = 2'd0;
    localparam logic [1:0] MODE_INTLV  = 2'd1;
    localparam logic [1:0] MODE_SKEW   = 2'd2;
endpackage

// File: rtl/pmbv_map.sv
module pmbv_map
    import pmbv_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [1:0]       mode_i,
    input  logic             stride_i,
    input  logic [POS_W-1:0] base_i,
    output logic [IDX_W-1:0] phys_o,
    output logic [IDX_W-1:0] row_o,
    output logic [IDX_W-1:0] sched_o
);
    localparam logic [POS_W-1:0] ROW_STEP = POS_W'(LANE);
    localparam logic [POS_W-1:0] COL_STEP = POS_W'(LANES * LANE);

    logic [POS_W-1:0] pos;
    logic [IDX_W-1:0] col;

    always_comb begin
        pos     = stride_i ? base_i + COL_STEP : base_i + ROW_STEP;
        row_o   = pos[3:2];
        col     = pos[1:0];
        phys_o  = mode_i[1] ? row_o + col : col;
        // in the single-bank mode all lanes contend for one wide port
        sched_o = (mode_i == MODE_SINGLE) ? '0 : phys_o;
    end
endmodule

// File: rtl/pmbv_sched.sv
module pmbv_sched
    import pmbv_pkg::*;
(
    input  logic [LANES-1:0][IDX_W-1:0] sched_i,
    input  logic [LANES-1:0][IDX_W-1:0] row_i,
    output logic [LANES-1:0][IDX_W-1:0] beat_o,
    output logic [IDX_W-1:0]            last_o
);
    logic [LANES-1:0] first_use;
    logic [IDX_W-1:0] cnt;

    always_comb begin
        first_use = '1;
        for (int i = 0; i < LANES; i++) begin
            for (int j = 0; j < LANES; j++) begin
                if (j < i && sched_i[j] == sched_i[i] && row_i[j] == row_i[i])
                    first_use[i] = 1'b0;
            end
        end
        last_o = '0;
        cnt    = '0;
        for (int i = 0; i < LANES; i++) begin
            cnt = '0;
            for (int j = 0; j < LANES; j++) begin
                if (j < i && sched_i[j] == sched_i[i] && row_i[j] != row_i[i] && first_use[j])
                    cnt = cnt + 1'b1;
            end
            beat_o[i] = cnt;
            if (cnt > last_o)
                last_o = cnt;
        end
    end
endmodule

// File: rtl/pmbv_bank.sv
module pmbv_bank #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            store_q[addr] <= wdata;
    end

    assign rdata = store_q[addr];
endmodule

// File: rtl/pmbv_mem.sv
module pmbv_mem
    import pmbv_pkg::*;
#(
    parameter int ELEM_W = 16,
    parameter int TILES  = 4,
    parameter int CNT_W  = 16,
    localparam int TILE_W = (TILES > 1) ? $clog2(TILES) : 1,
    localparam int DEPTH  = TILES * LANES,
    localparam int LINE_W = TILE_W + IDX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic                      req_write,
    input  logic [1:0]                req_mode,
    input  logic                      req_stride,
    input  logic [TILE_W-1:0]         req_tile,
    input  logic [POS_W-1:0]          req_base,
    input  logic [LANES*ELEM_W-1:0]   req_wdata,
    output logic                      rsp_valid,
    output logic [LANES*ELEM_W-1:0]   rsp_rdata,
    output logic [CNT_W-1:0]          stall_count
);
    typedef struct packed {
        logic                             busy;
        logic [IDX_W-1:0]                 beat;
        logic [IDX_W-1:0]                 last;
        logic                             write;
        logic [TILE_W-1:0]                tile;
        logic [LANES-1:0][IDX_W-1:0]      pbank;
        logic [LANES-1:0][IDX_W-1:0]      row;
        logic [LANES-1:0][IDX_W-1:0]      lbeat;
        logic [LANES-1:0][ELEM_W-1:0]     data;
        logic                             rsp;
        logic [CNT_W-1:0]                 stalls;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][IDX_W-1:0] map_bank, map_row, map_sched, sch_beat;
    logic [IDX_W-1:0]            sch_last;
    logic                        accept;

    logic [LANES-1:0]                bank_we;
    logic [LINE_W-1:0]               bank_addr [LANES];
    logic [ELEM_W-1:0]               bank_wd   [LANES];
    logic [ELEM_W-1:0]               bank_rd   [LANES];
    logic [LANES-1:0][LANES-1:0]     hit;      // [bank][lane]

    // per-lane address mapping
    for (genvar g = 0; g < LANES; g++) begin : g_map
        pmbv_map #(.LANE(g)) u_map (
            .mode_i   (req_mode),
            .stride_i (req_stride),
            .base_i   (req_base),
            .phys_o   (map_bank[g]),
            .row_o    (map_row[g]),
            .sched_o  (map_sched[g])
        );
    end

    pmbv_sched u_sched (
        .sched_i (map_sched),
        .row_i   (map_row),
        .beat_o  (sch_beat),
        .last_o  (sch_last)
    );

    // bank port steering for the current beat
    always_comb begin
        hit = '0;
        for (int k = 0; k < LANES; k++) begin
            bank_we[k]   = 1'b0;
            bank_addr[k] = {st_q.tile, {IDX_W{1'b0}}};
            bank_wd[k]   = '0;
            for (int i = 0; i < LANES; i++) begin
                if (st_q.busy && st_q.lbeat[i] == st_q.beat && st_q.pbank[i] == IDX_W'(k)) begin
                    hit[k][i]    = 1'b1;
                    bank_addr[k] = {st_q.tile, st_q.row[i]};
                    bank_we[k]   = st_q.write;
                    bank_wd[k]   = st_q.data[i];
                end
            end
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        pmbv_bank #(.W(ELEM_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .we    (bank_we[k]),
            .addr  (bank_addr[k]),
            .wdata (bank_wd[k]),
            .rdata (bank_rd[k])
        );
    end

    assign accept = req_valid && !st_q.busy;

    always_comb begin
        st_d     = st_q;
        st_d.rsp = 1'b0;
        if (st_q.busy) begin
            for (int i = 0; i < LANES; i++) begin
                if (!st_q.write && st_q.lbeat[i] == st_q.beat)
                    st_d.data[i] = bank_rd[st_q.pbank[i]];
            end
            if (st_q.beat != '0)
                st_d.stalls = st_q.stalls + 1'b1;
            if (st_q.beat == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.rsp  = !st_q.write;
            end else begin
                st_d.beat = st_q.beat + 1'b1;
            end
        end else if (accept) begin
            st_d.busy  = 1'b1;
            st_d.beat  = '0;
            st_d.last  = sch_last;
            st_d.write = req_write;
            st_d.tile  = req_tile;
            st_d.pbank = map_bank;
            st_d.row   = map_row;
            st_d.lbeat = sch_beat;
            st_d.data  = req_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign req_ready   = !st_q.busy;
    assign rsp_valid   = st_q.rsp;
    assign rsp_rdata   = st_q.data;
    assign stall_count = st_q.stalls;

    // R5
    skew_col_single_beat_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && req_mode[1] && req_stride) |-> (sch_last == '0));

    // R6
    accept_drops_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R7
    rsp_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready);

    // R9
    idle_no_stall_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req_ready) && !$past(rst)) |-> (stall_count == $past(stall_count)));

    // R2
    for (genvar k = 0; k < LANES; k++) begin : g_bank_chk
        one_lane_per_bank_chk: assert property (@(posedge clk) disable iff (rst)
            $countones(hit[k]) <= 1);
    end
endmodule

// File: tb/pmbv_mem_test.sv
`timescale 1ns/1ps
module pmbv_mem_test;
    localparam int EW = 16;
    localparam int NT = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic          req_stride = 1'b0;
    logic [1:0]    req_tile = 2'd0;
    logic [3:0]    req_base = 4'd0;
    logic [63:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [63:0]   rsp_rdata;
    logic [15:0]   stall_count;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_stalls = 0;
    logic [15:0] pm [4][NT*4];   // reference physical storage

    always #10 clk = ~clk;

    pmbv_mem uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mode(req_mode), .req_stride(req_stride),
        .req_tile(req_tile), .req_base(req_base), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .stall_count(stall_count)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // one access; entered and left at a falling edge
    task automatic access(input bit wr, input int mode, input bit colstr,
                          input int tile, input int base, input logic [63:0] wd,
                          input int exp_beats, input string tag);
        int pos[4]; int r[4]; int c[4]; int b[4];
        int beats; int cnt;
        logic [63:0] exp_rd;
        beats = 0;
        exp_rd = '0;
        for (int i = 0; i < 4; i++) begin
            pos[i] = colstr ? (base + 4*i) % 16 : (base + i) % 16;
            r[i] = pos[i] / 4;
            c[i] = pos[i] % 4;
            b[i] = (mode >= 2) ? (r[i] + c[i]) % 4 : c[i];
        end
        if (mode == 0) begin
            for (int rr = 0; rr < 4; rr++) begin
                cnt = 0;
                for (int i = 0; i < 4; i++) if (r[i] == rr) cnt = 1;
                beats += cnt;
            end
        end else begin
            for (int bb = 0; bb < 4; bb++) begin
                cnt = 0;
                for (int i = 0; i < 4; i++) if (b[i] == bb) cnt++;
                if (cnt > beats) beats = cnt;
            end
        end
        chk({tag, " beat count of model"}, 64'(beats), 64'(exp_beats));
        for (int i = 0; i < 4; i++) begin
            if (wr) pm[b[i]][tile*4 + r[i]] = wd[16*i +: 16];
            else    exp_rd[16*i +: 16] = pm[b[i]][tile*4 + r[i]];
        end
        exp_stalls += beats - 1;
        req_valid = 1'b1; req_write = wr; req_mode = 2'(mode); req_stride = colstr;
        req_tile = 2'(tile); req_base = 4'(base); req_wdata = wd;
        chk("R6 ready before accept", 64'(req_ready), 64'd1);
        for (int k = 0; k < beats; k++) begin
            @(negedge clk);
            if (k == 0) req_valid = 1'b0;
            chk({tag, " R6 ready low in beat"}, 64'(req_ready), 64'd0);
            chk("R7 no response during beats", 64'(rsp_valid), 64'd0);
        end
        @(negedge clk);
        chk({tag, " R6 ready back"}, 64'(req_ready), 64'd1);
        chk({tag, " R7 response flag"}, 64'(rsp_valid), 64'(!wr));
        if (!wr) chk({tag, " R8 read data"}, rsp_rdata, exp_rd);
        chk({tag, " R9 stall count"}, 64'(stall_count), 64'(exp_stalls));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            chk("R7 response is one cycle", 64'(rsp_valid), 64'd0);
            chk("R9 idle keeps count", 64'(stall_count), 64'(exp_stalls));
        end
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 ready", 64'(req_ready), 64'd1);
        chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 stall_count", 64'(stall_count), 64'd0);

        // fill every tile with interleaved aligned rows (R4: one beat each)
        for (int t = 0; t < NT; t++)
            for (int rr = 0; rr < 4; rr++)
                access(1'b1, 1, 1'b0, t, rr*4,
                       {16'(t*256+rr*16+3), 16'(t*256+rr*16+2), 16'(t*256+rr*16+1), 16'(t*256+rr*16)},
                       1, "R4 fill");

        // R4 / R2 interleaved reads
        access(1'b0, 1, 1'b1, 2, 1, '0, 4, "R4 column");
        access(1'b0, 1, 1'b0, 2, 6, '0, 1, "R4 unaligned row");
        access(1'b0, 1, 1'b0, 3, 15, '0, 1, "R2 row wraps tile");
        idle(2);

        // R3 single wide bank
        access(1'b0, 0, 1'b0, 1, 8, '0, 1, "R3 aligned row");
        access(1'b0, 0, 1'b0, 1, 14, '0, 2, "R3 row across boundary");
        access(1'b0, 0, 1'b1, 0, 3, '0, 4, "R3 column");

        // R5 / R8 skewed mode: column writes then reads
        for (int cc = 0; cc < 4; cc++)
            access(1'b1, 2, 1'b1, 1, cc, 64'h1000_2000_3000_4000 + 64'(cc * 16'h0101), 1, "R5 column write");
        access(1'b0, 2, 1'b1, 1, 2, '0, 1, "R5 column read");
        access(1'b0, 2, 1'b0, 1, 4, '0, 1, "R5 aligned row");
        access(1'b0, 2, 1'b0, 1, 5, '0, 2, "R5 unaligned row");
        access(1'b0, 3, 1'b1, 1, 9, '0, 1, "R5 mode 3 column");
        access(1'b0, 1, 1'b1, 1, 0, '0, 4, "R8 skew data seen interleaved");
        idle(1);
        // R8 other tiles untouched
        access(1'b0, 1, 1'b0, 0, 4, '0, 1, "R8 tile 0 intact");
        access(1'b0, 1, 1'b0, 2, 12, '0, 1, "R8 tile 2 intact");
        access(1'b1, 0, 1'b1, 3, 2, 64'hdead_beef_cafe_f00d, 4, "R8 single column write");
        access(1'b0, 0, 1'b1, 3, 2, '0, 4, "R8 single column read");
        access(1'b0, 2, 1'b0, 3, 3, '0, 2, "R8 skew read of same tile");

        // R9 / R1 synchronous reset clears the counter
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_stalls = 0;
        chk("R9 counter cleared", 64'(stall_count), 64'd0);
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        access(1'b0, 1, 1'b1, 0, 0, '0, 4, "R9 count after reset");
        idle(2);
        finish_run();
    end
endmodule